// File: doc/BRIEF.md
# Shared Bitmap Framebuffer Controller

This block owns an 8192-byte bitmap memory. A processor and a raster video scanner both use it by taking turns on alternate clocks. The block produces the processor clock phase, `phi2`. While `phi2` is high, the processor reads or writes any byte as ordinary memory, and the access always completes inside that phase, so no ready or wait signal exists. While `phi2` is low, the video scanner fetches the next display byte. It shifts that byte out one bit per pixel clock, most significant bit first. There is no glyph or font stage: every stored bit is exactly one pixel.

The scanner visits every byte once per frame. That sweep is the memory's only refresh, so the frame period must fit inside the refresh interval given as a parameter. The memory sits in two byte-interleaved banks, and address bit 0 picks the bank for each access.

Two small state machines give the block its structure. The phase machine has states `PH_VIDEO` and `PH_CPU`. It moves `PH_VIDEO -> PH_CPU -> PH_VIDEO` on every clock and starts in `PH_VIDEO` after reset. The raster region machine has states `RS_ACTIVE` (visible lines) and `RS_VBLANK`. It moves `RS_ACTIVE -> RS_VBLANK` at the end of the last visible line, and `RS_VBLANK -> RS_ACTIVE` at the end of the last line of the frame.

Top module: `bitmap_fb_ctl`

## Requirements
- R1: After reset, `phi2` is 0 in clock 0, the first clock after reset is released. It then toggles every clock, so it is 1 in odd clocks. Right after reset, `pix` is 0, `bank_cs` is 2'b00, `cpu_rdata` is 0 and `blank` is 1.
- R2: A processor read (`cpu_sel`=1, `cpu_we`=0) in a clock where `phi2`=1 returns the byte at `cpu_addr` on `cpu_rdata` from the next clock onward. `cpu_rdata` keeps that value until the next such read. A write in a `phi2`=1 clock stores `cpu_wdata` at `cpu_addr`.
- R3: A processor write changes only the addressed byte. Every other byte keeps its value.
- R4: `cpu_sel`, `cpu_we`, `cpu_addr` and `cpu_wdata` have no effect in a clock where `phi2`=0. Video fetches take place only in those clocks.
- R5: A processor access in every consecutive `phi2`=1 clock completes, whatever the scan position. A run of N writes takes at most 2N+2 clocks.
- R6: During a processor access, `bank_cs` is 2'b01 for an even address and 2'b10 for an odd address. A video fetch selects banks by the same rule using its scan address. In all other clocks `bank_cs` is 2'b00.
- R7: Let h be the clock index within a line (0 to H_TOTAL-1) and v be the line index (0 to V_TOTAL-1). Pixel x of visible line v appears on `pix` in clock h = x+8. Its value is bit 7-(x mod 8) of byte v*(H_ACT/8)+x/8, so pixels come out most significant bit first.
- R8: `blank` is 1 unless v < V_ACT and 8 <= h < H_ACT+8. While `blank` is 1, `pix` is 0.
- R9: `hsync` is 1 exactly when HS_START <= h < HS_END. `vsync` is 1 exactly when VS_START <= v < VS_END. Both are active high.
- R10: The scan fetches all H_ACT/8*V_ACT bytes once per frame, in ascending order, and wraps to address 0 at frame start. The frame period is H_TOTAL*V_TOTAL clocks and does not exceed REFRESH_CYCLES.
- R11: A byte written during one frame appears on screen in the next full frame that scans it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; one pixel per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | Processor access request, sampled when `phi2` is 1 |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, held until the next read |
| phi2 | output | 1 | Processor phase: 1 = processor slot, 0 = video slot |
| bank_cs | output | 2 | Bank selects: bit 0 even bank, bit 1 odd bank |
| pix | output | 1 | Serial pixel output |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| blank | output | 1 | 1 outside the visible window |

## Verification
The bench builds the block with a 32x8-pixel visible window inside a 48x10 raster, which gives a 32-byte memory (16 bytes per bank) and a 480-clock frame against a refresh limit of 600. With these values, whole frames can be compared pixel by pixel several times over. Every address can be read back after each isolated write. The frame wrap and the refresh limit come up within a few hundred clocks. Processor traffic lands at every scan position, which covers the cases where a processor slot sits next to a fetch slot.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

    // Which party owns the memory port in the current clock
    typedef enum logic {
        PH_VIDEO = 1'b0,
        PH_CPU   = 1'b1
    } phase_e;

    // Vertical region of the raster
    typedef enum logic {
        RS_ACTIVE = 1'b0,
        RS_VBLANK = 1'b1
    } region_e;

    localparam int BYTE_W   = 8;
    localparam int PIX_LAG  = 8;   // clocks from line start to first visible pixel
    localparam int FETCH_PH = 6;   // low-phase slot inside each 8-pixel group
    localparam int LOAD_PH  = 7;   // shift register reload slot

endpackage

// File: rtl/fbc_phase_gen.sv
module fbc_phase_gen
    import fbc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase_o,
    output logic   phi2_o
);

    phase_e phase_q;
    phase_e phase_d;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_VIDEO;
        else     phase_q <= phase_d;
    end

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_VIDEO: phase_d = PH_CPU;
            PH_CPU:   phase_d = PH_VIDEO;
            default:  phase_d = PH_VIDEO;
        endcase
    end

    always_comb begin
        phase_o = phase_q;
        phi2_o  = (phase_q == PH_CPU);
    end

    // R1
    video_to_cpu_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_VIDEO) |=> (phase_q == PH_CPU));

    // R1
    cpu_to_video_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_CPU) |=> (phase_q == PH_VIDEO));

endmodule

// File: rtl/fbc_raster.sv
module fbc_raster
    import fbc_pkg::*;
#(
    parameter int H_ACT          = 256,
    parameter int H_TOTAL        = 320,
    parameter int HS_START       = 280,
    parameter int HS_END         = 304,
    parameter int V_ACT          = 256,
    parameter int V_TOTAL        = 280,
    parameter int VS_START       = 260,
    parameter int VS_END         = 264,
    parameter int ADDR_W         = 13,
    parameter int REFRESH_CYCLES = 250000
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase_i,
    output logic              fetch_o,
    output logic              load_o,
    output logic [ADDR_W-1:0] scan_addr_o,
    output logic              active_o,
    output logic              hsync_o,
    output logic              vsync_o
);

    localparam int HW = $clog2(H_TOTAL);
    localparam int VW = $clog2(V_TOTAL);
    localparam int RW = $clog2(REFRESH_CYCLES + 1) + 1;
    localparam logic [HW-1:0] H_LAST   = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0] V_LAST   = VW'(V_TOTAL - 1);
    localparam logic [VW-1:0] V_VISEND = VW'(V_ACT - 1);
    localparam logic [RW-1:0] RW_MAX   = {RW{1'b1}};

    logic [HW-1:0]     h_q;
    logic [VW-1:0]     v_q;
    logic [ADDR_W-1:0] scan_q;
    region_e           region_q;
    region_e           region_d;
    logic              line_end;
    logic              frame_end;
    logic              last_vis;

    always_comb begin
        line_end  = (h_q == H_LAST);
        frame_end = line_end && (v_q == V_LAST);
        last_vis  = line_end && (v_q == V_VISEND);
    end

    // Region state register
    always_ff @(posedge clk) begin
        if (rst) region_q <= RS_ACTIVE;
        else     region_q <= region_d;
    end

    // Region transitions
    always_comb begin
        region_d = region_q;
        unique case (region_q)
            RS_ACTIVE: if (last_vis)  region_d = RS_VBLANK;
            RS_VBLANK: if (frame_end) region_d = RS_ACTIVE;
            default:                  region_d = RS_ACTIVE;
        endcase
    end

    // Horizontal and vertical position
    always_ff @(posedge clk) begin
        if (rst) begin
            h_q <= '0;
            v_q <= '0;
        end else if (line_end) begin
            h_q <= '0;
            v_q <= frame_end ? '0 : v_q + 1'b1;
        end else begin
            h_q <= h_q + 1'b1;
        end
    end

    // Scan address: one step per fetch, back to zero each frame
    always_ff @(posedge clk) begin
        if (rst || frame_end) scan_q <= '0;
        else if (fetch_o)     scan_q <= scan_q + 1'b1;
    end

    // Outputs decoded from the region state and position
    always_comb begin
        fetch_o     = (region_q == RS_ACTIVE) && (h_q[2:0] == 3'(FETCH_PH))
                      && (int'(h_q) < H_ACT);
        load_o      = (h_q[2:0] == 3'(LOAD_PH));
        active_o    = (region_q == RS_ACTIVE) && (int'(h_q) >= PIX_LAG)
                      && (int'(h_q) < H_ACT + PIX_LAG);
        hsync_o     = (int'(h_q) >= HS_START) && (int'(h_q) < HS_END);
        vsync_o     = (int'(v_q) >= VS_START) && (int'(v_q) < VS_END);
        scan_addr_o = scan_q;
    end

    // Clocks since address zero was last swept; bounds the refresh gap
    logic [RW-1:0] refr_q;
    always_ff @(posedge clk) begin
        if (rst)                           refr_q <= '0;
        else if (fetch_o && scan_q == '0)  refr_q <= '0;
        else if (refr_q != RW_MAX)         refr_q <= refr_q + 1'b1;
    end

    // R4
    fetch_phase_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_o |-> (phase_i == PH_VIDEO));

    // R10
    scan_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_o && v_q == '0 && h_q == HW'(FETCH_PH)) |-> (scan_q == '0));

    // R10
    refresh_window_chk: assert property (@(posedge clk) disable iff (rst)
        int'(refr_q) <= REFRESH_CYCLES);

endmodule

// File: rtl/fbc_bank_mem.sv
module fbc_bank_mem
    import fbc_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              en_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic [1:0]        cs_o
);

    localparam int BANK_AW    = ADDR_W - 1;
    localparam int BANK_DEPTH = 2 ** BANK_AW;

    logic [BYTE_W-1:0] rd [2];
    logic [BANK_AW-1:0] row;

    assign row = addr_i[ADDR_W-1:1];

    // Two byte-interleaved banks: bank 0 even bytes, bank 1 odd bytes
    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic [BYTE_W-1:0] cells [BANK_DEPTH];

        assign cs_o[g] = en_i && (addr_i[0] == 1'(g));

        always_ff @(posedge clk) begin
            if (cs_o[g] && we_i) cells[row] <= wdata_i;
        end

        assign rd[g] = cells[row];
    end

    assign rdata_o = rd[addr_i[0]];

endmodule

// File: rtl/fbc_pixel_shift.sv
module fbc_pixel_shift
    import fbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              active_i,
    output logic              pix_o
);

    logic [BYTE_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)         sh_q <= '0;
        else if (load_i) sh_q <= byte_i;
        else             sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
    end

    assign pix_o = active_i && sh_q[BYTE_W-1];

endmodule

// File: rtl/bitmap_fb_ctl.sv
module bitmap_fb_ctl
    import fbc_pkg::*;
#(
    parameter int H_ACT          = 256,
    parameter int H_TOTAL        = 320,
    parameter int HS_START       = 280,
    parameter int HS_END         = 304,
    parameter int V_ACT          = 256,
    parameter int V_TOTAL        = 280,
    parameter int VS_START       = 260,
    parameter int VS_END         = 264,
    parameter int REFRESH_CYCLES = 250000,
    localparam int DEPTH         = (H_ACT / 8) * V_ACT,
    localparam int ADDR_W        = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic              phi2,
    output logic [1:0]        bank_cs,
    output logic              pix,
    output logic              hsync,
    output logic              vsync,
    output logic              blank
);

    phase_e            phase;
    logic              fetch;
    logic              load;
    logic              active;
    logic [ADDR_W-1:0] scan_addr;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_en;
    logic              mem_we;
    logic [7:0]        mem_rdata;
    logic [7:0]        fetch_q;
    logic [7:0]        rdata_q;

    fbc_phase_gen u_phase (
        .clk     (clk),
        .rst     (rst),
        .phase_o (phase),
        .phi2_o  (phi2)
    );

    fbc_raster #(
        .H_ACT          (H_ACT),
        .H_TOTAL        (H_TOTAL),
        .HS_START       (HS_START),
        .HS_END         (HS_END),
        .V_ACT          (V_ACT),
        .V_TOTAL        (V_TOTAL),
        .VS_START       (VS_START),
        .VS_END         (VS_END),
        .ADDR_W         (ADDR_W),
        .REFRESH_CYCLES (REFRESH_CYCLES)
    ) u_raster (
        .clk         (clk),
        .rst         (rst),
        .phase_i     (phase),
        .fetch_o     (fetch),
        .load_o      (load),
        .scan_addr_o (scan_addr),
        .active_o    (active),
        .hsync_o     (hsync),
        .vsync_o     (vsync)
    );

    // Port owner per phase
    always_comb begin
        mem_addr = scan_addr;
        mem_en   = 1'b0;
        mem_we   = 1'b0;
        unique case (phase)
            PH_CPU: begin
                mem_addr = cpu_addr;
                mem_en   = cpu_sel;
                mem_we   = cpu_sel && cpu_we;
            end
            PH_VIDEO: begin
                mem_addr = scan_addr;
                mem_en   = fetch;
                mem_we   = 1'b0;
            end
            default: ;
        endcase
    end

    fbc_bank_mem #(
        .ADDR_W (ADDR_W)
    ) u_mem (
        .clk     (clk),
        .en_i    (mem_en),
        .we_i    (mem_we),
        .addr_i  (mem_addr),
        .wdata_i (cpu_wdata),
        .rdata_o (mem_rdata),
        .cs_o    (bank_cs)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_q <= '0;
            rdata_q <= '0;
        end else begin
            if (phase == PH_VIDEO && fetch)                  fetch_q <= mem_rdata;
            if (phase == PH_CPU && cpu_sel && !cpu_we)       rdata_q <= mem_rdata;
        end
    end

    assign cpu_rdata = rdata_q;
    assign blank     = !active;

    fbc_pixel_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .byte_i   (fetch_q),
        .active_i (active),
        .pix_o    (pix)
    );

    // R6
    bank_pick_chk: assert property (@(posedge clk) disable iff (rst)
        (phi2 && cpu_sel) |-> (bank_cs == (cpu_addr[0] ? 2'b10 : 2'b01)));

    // R8
    blank_dark_chk: assert property (@(posedge clk) disable iff (rst)
        blank |-> !pix);

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(phi2 && cpu_sel && !cpu_we) |=> $stable(cpu_rdata));

endmodule

// File: tb/tb_bitmap_fb_ctl.sv
module tb_bitmap_fb_ctl;

    localparam int HA = 32, HT = 48, HSS = 40, HSE = 44;
    localparam int VA = 8,  VT = 10, VSS = 8,  VSE = 9;
    localparam int REF   = 600;
    localparam int BPL   = HA / 8;
    localparam int DEPTH = BPL * VA;
    localparam int AW    = $clog2(DEPTH);
    localparam int FRAME = HT * VT;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_sel = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [7:0]    cpu_wdata = '0;
    logic [7:0]    cpu_rdata;
    logic          phi2;
    logic [1:0]    bank_cs;
    logic          pix, hsync, vsync, blank;

    bitmap_fb_ctl #(
        .H_ACT(HA), .H_TOTAL(HT), .HS_START(HSS), .HS_END(HSE),
        .V_ACT(VA), .V_TOTAL(VT), .VS_START(VSS), .VS_END(VSE),
        .REFRESH_CYCLES(REF)
    ) dut (
        .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .phi2(phi2), .bank_cs(bank_cs), .pix(pix), .hsync(hsync),
        .vsync(vsync), .blank(blank)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    logic [7:0] model [DEPTH];
    int  n_total = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int hpos(int c); return c % HT; endfunction
    function automatic int vpos(int c); return (c / HT) % VT; endfunction

    function automatic bit exp_vis(int c);
        int h = hpos(c); int v = vpos(c);
        return (v < VA) && (h >= 8) && (h < HA + 8);
    endfunction

    function automatic logic exp_pix(int c);
        int h = hpos(c); int v = vpos(c); int x; int a;
        if (!exp_vis(c)) return 1'b0;
        x = h - 8;
        a = v * BPL + x / 8;
        return model[a][7 - (x % 8)];
    endfunction

    function automatic logic [1:0] exp_idle_cs(int c);
        int h = hpos(c); int v = vpos(c);
        if (v < VA && (h % 8) == 6 && h < HA)
            return ((v * BPL + h / 8) % 2 == 1) ? 2'b10 : 2'b01;
        return 2'b00;
    endfunction

    task automatic wait_cpu_phase();
        do @(negedge clk); while (!phi2);
    endtask

    task automatic cpu_write(input int a, input logic [7:0] d);
        wait_cpu_phase();
        cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = AW'(a); cpu_wdata = d;
        #1;
        // R6: bank select follows address bit 0
        chk(bank_cs == ((a % 2) ? 2'b10 : 2'b01), "R6 bank_cs on write",
            int'(bank_cs), (a % 2) ? 2 : 1);
        @(negedge clk);
        cpu_sel = 1'b0; cpu_we = 1'b0;
        model[a] = d;
    endtask

    task automatic cpu_read(input int a, output logic [7:0] d);
        wait_cpu_phase();
        cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = AW'(a);
        @(negedge clk);
        d = cpu_rdata;
        cpu_sel = 1'b0;
    endtask

    task automatic count_mismatch(output int bad);
        logic [7:0] d;
        bad = 0;
        for (int a = 0; a < DEPTH; a++) begin
            cpu_read(a, d);
            if (d !== model[a]) bad++;
        end
    endtask

    task automatic compare_frame(input string req);
        int bp = 0, bb = 0, bd = 0, bs = 0, bc = 0;
        @(negedge clk);
        while (cyc % FRAME != 0) @(negedge clk);
        for (int i = 0; i < FRAME; i++) begin
            if (pix !== exp_pix(cyc)) bp++;
            if (blank !== !exp_vis(cyc)) bb++;
            if (blank && pix !== 1'b0) bd++;
            if (hsync !== (hpos(cyc) >= HSS && hpos(cyc) < HSE) ||
                vsync !== (vpos(cyc) >= VSS && vpos(cyc) < VSE)) bs++;
            if (bank_cs !== exp_idle_cs(cyc)) bc++;
            @(negedge clk);
        end
        chk(bp == 0, {req, " pixel map"}, bp, 0);
        chk(bb == 0, "R8 blank window", bb, 0);
        chk(bd == 0, "R8 pix dark in blank", bd, 0);
        chk(bs == 0, "R9 sync timing", bs, 0);
        chk(bc == 0, "R6 fetch bank_cs", bc, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin : main
        int seed;
        int t0, bad, v1, v2;
        logic [7:0] d, held;
        seed = $urandom(32'h1F2E3D4C);

        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state in clock 0
        chk(phi2 == 1'b0, "R1 phi2 after reset", int'(phi2), 0);
        chk(pix == 1'b0 && bank_cs == 2'b00 && blank == 1'b1, "R1 outputs after reset",
            int'({pix, bank_cs, blank}), 1);
        chk(cpu_rdata == 8'h00, "R1 rdata after reset", int'(cpu_rdata), 0);
        @(negedge clk);
        chk(phi2 == 1'b1, "R1 phi2 toggles", int'(phi2), 1);

        // R5: back-to-back writes across scan positions
        t0 = cyc;
        for (int a = 0; a < DEPTH; a++) cpu_write(a, 8'($urandom));
        chk(cyc - t0 <= 2 * DEPTH + 2, "R5 no wait states", cyc - t0, 2 * DEPTH + 2);

        // R2: readback of every byte
        for (int a = 0; a < DEPTH; a++) begin
            cpu_read(a, d);
            chk(d === model[a], "R2 readback", int'(d), int'(model[a]));
        end

        // R2: read data held across writes
        cpu_read(5, held);
        cpu_write(6, 8'h3C);
        cpu_write(9, 8'hC3);
        repeat (7) @(negedge clk);
        chk(cpu_rdata === held, "R2 rdata held", int'(cpu_rdata), int'(held));

        // R7, R8, R9, R6 over a full frame
        compare_frame("R7");

        // R10: frame period and refresh bound
        @(negedge clk);
        while (!(vsync && vpos(cyc) == VSS && hpos(cyc) == 0)) @(negedge clk);
        v1 = cyc;
        @(negedge clk);
        while (!(vsync && vpos(cyc) == VSS && hpos(cyc) == 0)) @(negedge clk);
        v2 = cyc;
        chk(v2 - v1 == FRAME, "R10 frame period", v2 - v1, FRAME);
        chk(v2 - v1 <= REF, "R10 within refresh", v2 - v1, REF);

        // R3: isolation, corners and random spots
        cpu_write(0, 8'hFF);
        count_mismatch(bad);
        chk(bad == 0, "R3 isolation addr 0", bad, 0);
        cpu_write(DEPTH - 1, 8'h01);
        count_mismatch(bad);
        chk(bad == 0, "R3 isolation last addr", bad, 0);
        for (int k = 0; k < 3; k++) begin
            cpu_write(int'($urandom % DEPTH), 8'($urandom));
            count_mismatch(bad);
            chk(bad == 0, "R3 isolation random", bad, 0);
        end

        // R4: strobes during phi2 low are ignored
        for (int k = 0; k < 4; k++) begin
            int a = (k == 0) ? 0 : int'($urandom % DEPTH);
            do @(negedge clk); while (phi2);
            cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = AW'(a); cpu_wdata = ~model[a];
            @(negedge clk);
            cpu_sel = 1'b0; cpu_we = 1'b0;
            cpu_read(a, d);
            chk(d === model[a], "R4 low-phase write ignored", int'(d), int'(model[a]));
        end

        // R11: writes show up on the next full frame
        for (int k = 0; k < 8; k++) cpu_write(int'($urandom % DEPTH), 8'($urandom));
        cpu_write(BPL * (VA - 1), 8'hA5);
        compare_frame("R11");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule